// File: doc/BRIEF.md
# Programmable Pattern Coincidence Trigger

This block watches five asynchronous pulse lines and raises a single trigger pulse whenever the current set of active lines is one that a programmable truth table marks as interesting. The truth table is a 32-bit word with one bit for each possible combination of the five lines. Any Boolean function of the inputs can therefore be chosen at run time, for example a plain OR of every line, or a strict coincidence of two specific lines.

The truth table is written from a configuration clock domain. A single-cycle load strobe on that clock captures the word. A toggle handshake then carries the word across to the logic clock domain, where it replaces the active table in one step. The inputs pass through a two-flop synchronizer in the logic domain before the lookup. A trigger is issued only on the cycle where the lookup result turns from false to true, so an input that is held high produces one pulse.

Top module: `coinc_trigger`

## Requirements
- R1: While reset is asserted and on the first cycles after it, trig_o is low. Out of reset the active table is 32'hFFFF_FFFE, so any non-zero input combination fires, which makes the block an OR of all five lines.
- R2: Each trigger on trig_o lasts exactly one clk_logic cycle. An input combination held for many cycles gives exactly one pulse.
- R3: When the inputs are changed between two clk_logic edges, trig_o goes high after the third following rising edge of clk_logic: two synchronizer flops, then the output register.
- R4: Table bit k belongs to the input combination whose binary value is k, with trig_in[0] as the least significant index bit. For example, table bit 5 selects trig_in[0] and trig_in[2] high with the other lines low.
- R5: The all-zero input combination never fires, even when table bit 0 is set.
- R6: When cfg_load is high at one clk_cfg rising edge, cfg_pattern is captured, and a few clk_logic cycles later it becomes the active table. A coincidence table that needs trig_in[1] and trig_in[3] both high fires only when both of those lines are high.
- R7: While cfg_load is low, changes on cfg_pattern have no effect on the active table.
- R8: A move from one firing combination straight to another firing combination, with no non-firing cycle between them, produces no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_logic | input | 1 | Logic clock; synchronizer, lookup and output run on it |
| clk_cfg | input | 1 | Configuration clock for table loading |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| trig_in | input | 5 | Asynchronous pulse inputs |
| cfg_pattern | input | 32 | Truth table word to load |
| cfg_load | input | 1 | One clk_cfg cycle high loads cfg_pattern |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench drives each line alone under the reset table, holds inputs for long stretches to catch a level output or a repeated pulse, and measures the exact cycle of the first pulse. This catches a missing or an extra synchronizer stage. It loads a table with only bit 0 set and applies all-zero inputs, so a design that looks up combination zero would fire falsely. It also uses single-bit tables whose index tells the two bit orders apart, which would expose a reversed input order. Further tests change the pattern bus without a strobe and move directly between two firing combinations. A design that loads on the level of the bus, or that edge-detects the inputs instead of the lookup result, would fire where none is expected.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
    // Number of trigger lines and derived truth-table width
    localparam int unsigned CO_INPUTS      = 5;
    localparam int unsigned CO_PAT_W       = 1 << CO_INPUTS;
    localparam int unsigned CO_SYNC_STAGES = 2;
endpackage

// File: rtl/coinc_cfg_capture.sv
module coinc_cfg_capture #(
    parameter int unsigned PAT_W = 32,
    parameter logic [PAT_W-1:0] DFLT = '0
) (
    input  logic             clk_cfg,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic [PAT_W-1:0] hold_o,
    output logic             tgl_o
);
    typedef struct packed {
        logic [PAT_W-1:0] hold;
        logic             tgl;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.hold = pat_i;
            st_d.tgl  = ~st_q.tgl;
        end
    end

    always_ff @(posedge clk_cfg or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= DFLT;
            st_q.tgl  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
    assign tgl_o  = st_q.tgl;

    AST_HOLD_STABLE: assert property (@(posedge clk_cfg) disable iff (!rst_n)
        !load_i |=> $stable(hold_o)); // R7
endmodule

// File: rtl/coinc_cfg_apply.sv
module coinc_cfg_apply #(
    parameter int unsigned PAT_W = 32,
    parameter int unsigned SYNC  = 2,
    parameter logic [PAT_W-1:0] DFLT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl_i,
    input  logic [PAT_W-1:0] hold_i,
    output logic [PAT_W-1:0] pat_o
);
    typedef struct packed {
        logic [SYNC-1:0]  sync;
        logic             seen;
        logic [PAT_W-1:0] pat;
    } app_st_t;

    app_st_t st_d, st_q;
    logic    upd;

    always_comb begin
        st_d      = st_q;
        upd       = st_q.sync[SYNC-1] ^ st_q.seen;
        st_d.sync = {st_q.sync[SYNC-2:0], tgl_i};
        st_d.seen = st_q.sync[SYNC-1];
        if (upd) begin
            st_d.pat = hold_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '0;
            st_q.seen <= 1'b0;
            st_q.pat  <= DFLT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pat_o = st_q.pat;

    AST_PAT_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(pat_o)); // R6
endmodule

// File: rtl/coinc_in_sync.sv
module coinc_in_sync #(
    parameter int unsigned N_IN   = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] raw_i,
    output logic [N_IN-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][N_IN-1:0] pipe;
    } sy_st_t;

    sy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import coinc_pkg::*;
#(
    parameter int unsigned N_IN        = CO_INPUTS,
    parameter int unsigned SYNC_STAGES = CO_SYNC_STAGES
) (
    input  logic                    clk_logic,
    input  logic                    clk_cfg,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         trig_in,
    input  logic [(1 << N_IN)-1:0]  cfg_pattern,
    input  logic                    cfg_load,
    output logic                    trig_o
);
    localparam int unsigned PAT_W = 1 << N_IN;
    // Reset table: every combination except all-zero fires (OR of inputs)
    localparam logic [PAT_W-1:0] DFLT = {{(PAT_W-1){1'b1}}, 1'b0};

    logic [PAT_W-1:0] hold_pat;
    logic             hold_tgl;
    logic [PAT_W-1:0] act_pat;
    logic [N_IN-1:0]  in_vec;

    coinc_cfg_capture #(.PAT_W(PAT_W), .DFLT(DFLT)) u_cap (
        .clk_cfg (clk_cfg),
        .rst_n   (rst_n),
        .load_i  (cfg_load),
        .pat_i   (cfg_pattern),
        .hold_o  (hold_pat),
        .tgl_o   (hold_tgl)
    );

    coinc_cfg_apply #(.PAT_W(PAT_W), .SYNC(SYNC_STAGES), .DFLT(DFLT)) u_app (
        .clk    (clk_logic),
        .rst_n  (rst_n),
        .tgl_i  (hold_tgl),
        .hold_i (hold_pat),
        .pat_o  (act_pat)
    );

    coinc_in_sync #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_logic),
        .rst_n  (rst_n),
        .raw_i  (trig_in),
        .sync_o (in_vec)
    );

    typedef struct packed {
        logic hit;
        logic trig;
    } tr_st_t;

    tr_st_t st_d, st_q;
    logic   hit_now;

    always_comb begin
        st_d     = st_q;
        hit_now  = (in_vec != '0) && act_pat[in_vec];
        st_d.hit  = hit_now;
        st_d.trig = hit_now && !st_q.hit;
    end

    always_ff @(posedge clk_logic or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = st_q.trig;

    AST_ONE_CYCLE: assert property (@(posedge clk_logic) disable iff (!rst_n)
        trig_o |=> !trig_o); // R2
    AST_ZERO_QUIET: assert property (@(posedge clk_logic) disable iff (!rst_n)
        trig_o |-> ($past(in_vec) != '0)); // R5
    AST_TABLE_HIT: assert property (@(posedge clk_logic) disable iff (!rst_n)
        trig_o |-> $past(act_pat[in_vec])); // R4
endmodule

// File: tb/tb_coinc_trigger.sv
module tb_coinc_trigger;
    logic        clk_logic = 1'b0;
    logic        clk_cfg   = 1'b0;
    logic        rst_n     = 1'b0;
    logic [4:0]  trig_in   = '0;
    logic [31:0] cfg_pattern = '0;
    logic        cfg_load  = 1'b0;
    logic        trig_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #10 clk_logic = ~clk_logic;
    always #15 clk_cfg   = ~clk_cfg;

    coinc_trigger dut (
        .clk_logic   (clk_logic),
        .clk_cfg     (clk_cfg),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .cfg_pattern (cfg_pattern),
        .cfg_load    (cfg_load),
        .trig_o      (trig_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive inputs, watch 10 cycles; count pulses, high cycles and first index
    task automatic observe(input logic [4:0] v, input int exp_pulses, input bit idle_after,
                           input string tag);
        int pulses = 0;
        int highs  = 0;
        int first  = -1;
        logic prev = 1'b0;
        @(negedge clk_logic);
        trig_in = v;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk_logic);
            if (trig_o) begin
                highs++;
                if (first < 0) first = i;
                if (!prev) pulses++;
            end
            prev = trig_o;
        end
        check(pulses == exp_pulses, tag, pulses, exp_pulses);
        if (exp_pulses == 1) begin
            check(highs == 1, {tag, " R2 width"}, highs, 1);
            check(first == 3, {tag, " R3 latency"}, first, 3);
        end
        if (idle_after) begin
            trig_in = '0;
            highs = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk_logic);
                if (trig_o) highs++;
            end
            check(highs == 0, {tag, " R2 no pulse on release"}, highs, 0);
        end
    endtask

    task automatic load_pattern(input logic [31:0] p);
        @(negedge clk_cfg);
        cfg_pattern = p;
        cfg_load    = 1'b1;
        @(negedge clk_cfg);
        cfg_load    = 1'b0;
        repeat (8) @(negedge clk_logic);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk_logic);
        check(trig_o == 1'b0, "R1 in reset", trig_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_logic);
        check(trig_o == 1'b0, "R1 after reset", trig_o, 0);
    endtask

    task automatic t_default_or();
        for (int i = 0; i < 5; i++) begin
            observe(5'(1 << i), 1, 1'b1, $sformatf("R1 OR line %0d", i));
        end
        observe(5'b11111, 1, 1'b1, "R1 OR all lines");
    endtask

    task automatic t_zero();
        load_pattern(32'h0000_0001);
        observe(5'b00000, 0, 1'b0, "R5 zero combination");
        observe(5'b00001, 0, 1'b1, "R5 clear bit one");
    endtask

    task automatic t_bit_order();
        load_pattern(32'h0000_0020);
        observe(5'b00101, 1, 1'b1, "R4 index 5");
        observe(5'b10100, 0, 1'b1, "R4 reversed index");
    endtask

    task automatic t_coincidence();
        logic [31:0] p = '0;
        for (int k = 0; k < 32; k++) begin
            if (k[1] && k[3]) p[k] = 1'b1;
        end
        load_pattern(p);
        observe(5'b00010, 0, 1'b1, "R6 line 1 only");
        observe(5'b01000, 0, 1'b1, "R6 line 3 only");
        observe(5'b01010, 1, 1'b1, "R6 lines 1 and 3");
        observe(5'b01010, 1, 1'b0, "R8 first hit");
        observe(5'b11010, 0, 1'b1, "R8 hit to hit");
    endtask

    task automatic t_no_strobe();
        @(negedge clk_cfg);
        cfg_pattern = 32'h0000_0000;
        repeat (8) @(negedge clk_logic);
        observe(5'b01010, 1, 1'b1, "R7 bus change ignored");
    endtask

    initial begin
        t_reset();
        t_default_or();
        t_zero();
        t_bit_order();
        t_coincidence();
        t_no_strobe();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_logic);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule